// File: doc/BRIEF.md
# Address Decode Window Unit

This block sits between a transaction source and an interconnect and decides where each outgoing physical address goes. It holds a bank of programmable decode windows. Each window covers a naturally aligned, power-of-two region at 64 KB granularity and names a 4-bit destination and an 8-bit attribute for any address inside it. The lowest-numbered windows can also swap the upper address bits for a programmed value, which relocates the region at the destination. All other windows forward the address unchanged.

Software programs the windows through a small register port. A write takes effect on the clock edge where it is presented. A read returns its data one cycle after the request. The lookup port is purely combinational. It reports a hit, the destination, the attribute, the translated address and the winning window index. Four DRAM chip-select base/size pairs arrive as static input words. They can be read through a second register space and drive a separate DRAM-hit result for the same lookup address.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window register reads back zero, and no lookup address produces a window hit.
- R2: reg_addr[8]=0 selects window space. The group for window i starts at byte offset 16*i when i is 0..7, and at 0x90+8*(i-8) when i is 8..19. Control sits at group offset 0, base at 4, and on windows 0..7 remap-low at 8 and remap-high at 12. Read data appears on reg_rdata in the cycle after reg_rd is sampled, and reg_rdata is zero in any other cycle.
- R3: In the control word, bit 0 is enable, bits 7:4 are the target, bits 15:8 are the attribute and bits 31:16 are the size mask (size in 64 KB units minus one). Control bits 3:1 read zero. Base and remap-low keep only bits 31:16, and their bits 15:0 read zero. Remap-high keeps all 32 bits.
- R4: An enabled window hits when (lk_addr[31:16] & ~mask) equals (base[31:16] & ~mask).
- R5: When several windows hit, the lowest index wins. Its index, target and attribute appear on the lookup outputs.
- R6: On a hit in windows 0..7, lk_xaddr[31:16] takes remap-low bits where the mask is 0 and lk_addr bits where the mask is 1. lk_xaddr[15:0] always equals lk_addr[15:0].
- R7: On a hit in windows 8..19 lk_xaddr equals lk_addr. With no hit, lk_xaddr equals lk_addr and lk_target, lk_attr and lk_win are zero.
- R8: A window whose enable bit is 0 never hits, even when its base matches. Writing zero to its control and base disables it.
- R9: reg_addr[8]=1 selects the chip-select space. Offset 8*c reads cs_base word c and offset 8*c+4 reads cs_size word c, for c = 0..3. Writes to this space change nothing.
- R10: Chip-select c hits when size bit 0 is 1, base bits 3:0 are zero, and (lk_addr[31:24] & ~size[31:24]) equals (base[31:24] & ~size[31:24]). The lowest hitting c appears on dram_cs. Otherwise dram_hit and dram_cs are 0.
- R11: Window-space offsets that belong to no register (0x80..0x8F, 0xF0..0xFF) read zero, and writes to them change no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 9 | Byte offset; bit 8 selects chip-select space |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| lk_addr | input | 32 | Address to decode |
| lk_hit | output | 1 | Some window hit |
| lk_target | output | 4 | Target of the winning window |
| lk_attr | output | 8 | Attribute of the winning window |
| lk_xaddr | output | 32 | Translated address |
| lk_win | output | 5 | Index of the winning window |
| cs_base | input | 128 | Chip-select base words, c*32 upward |
| cs_size | input | 128 | Chip-select size words, c*32 upward |
| dram_hit | output | 1 | Some chip-select hit |
| dram_cs | output | 2 | Index of the winning chip-select |

## Verification
The lookup path has no pipeline, so a corrupted window field shows up at the lookup outputs within the same cycle. It appears as a wrong target, attribute or index, a missing hit, or stray upper address bits. A mis-decoded register offset, or a lost field mask, shows one cycle after a read of the affected group. It can also show as a lookup that changes after a write to an unrelated offset. Random window contents paired with addresses placed inside programmed regions drive lookups into the priority and remap paths. Directed cases cover the edges of the offset map and the chip-select exclusions.

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int NUM_CS    = 4,
  localparam int WIN_W    = $clog2(NUM_WIN),
  localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [8:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic [31:0]            lk_addr,
  output logic                   lk_hit,
  output logic [3:0]             lk_target,
  output logic [7:0]             lk_attr,
  output logic [31:0]            lk_xaddr,
  output logic [WIN_W-1:0]       lk_win,
  input  logic [NUM_CS*32-1:0]   cs_base,
  input  logic [NUM_CS*32-1:0]   cs_size,
  output logic                   dram_hit,
  output logic [CS_W-1:0]        dram_cs
);

  localparam int SPLIT = NUM_REMAP * 16 + 16;

  function automatic int grp_off(int i);
    return (i < NUM_REMAP) ? i * 16 : SPLIT + (i - NUM_REMAP) * 8;
  endfunction

  logic [NUM_WIN-1:0] w_en;
  logic [3:0]         w_tgt  [NUM_WIN];
  logic [7:0]         w_attr [NUM_WIN];
  logic [15:0]        w_msk  [NUM_WIN];
  logic [15:0]        w_base [NUM_WIN];
  logic [31:0]        w_xlat [NUM_WIN];
  logic [31:0]        w_ctrl_rd [NUM_WIN];
  logic [31:0]        w_rlo_rd  [NUM_WIN];
  logic [31:0]        w_rhi_rd  [NUM_WIN];
  logic [NUM_WIN-1:0] w_match;
  logic [NUM_CS-1:0]  c_match;
  logic [31:0]        rd_val;

  wire win_space = !reg_addr[8];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    localparam int OFF = grp_off(g);
    wire wr_ctrl = reg_wr && win_space && reg_addr[7:0] == 8'(OFF);
    wire wr_base = reg_wr && win_space && reg_addr[7:0] == 8'(OFF + 4);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        w_en[g]   <= 1'b0;
        w_tgt[g]  <= '0;
        w_attr[g] <= '0;
        w_msk[g]  <= '0;
        w_base[g] <= '0;
      end else begin
        if (wr_ctrl) begin
          w_en[g]   <= reg_wdata[0];
          w_tgt[g]  <= reg_wdata[7:4];
          w_attr[g] <= reg_wdata[15:8];
          w_msk[g]  <= reg_wdata[31:16];
        end
        if (wr_base) w_base[g] <= reg_wdata[31:16];
      end
    end

    assign w_ctrl_rd[g] = {w_msk[g], w_attr[g], w_tgt[g], 3'b000, w_en[g]};
    assign w_match[g]   = w_en[g] &&
                          ((lk_addr[31:16] & ~w_msk[g]) == (w_base[g] & ~w_msk[g]));

    if (g < NUM_REMAP) begin : g_remap
      logic [15:0] rlo;
      logic [31:0] rhi;
      wire wr_rlo = reg_wr && win_space && reg_addr[7:0] == 8'(OFF + 8);
      wire wr_rhi = reg_wr && win_space && reg_addr[7:0] == 8'(OFF + 12);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rlo <= '0;
          rhi <= '0;
        end else begin
          if (wr_rlo) rlo <= reg_wdata[31:16];
          if (wr_rhi) rhi <= reg_wdata;
        end
      end
      assign w_rlo_rd[g] = {rlo, 16'h0};
      assign w_rhi_rd[g] = rhi;
      assign w_xlat[g]   = {(rlo & ~w_msk[g]) | (lk_addr[31:16] & w_msk[g]), lk_addr[15:0]};
    end else begin : g_plain
      assign w_rlo_rd[g] = '0;
      assign w_rhi_rd[g] = '0;
      assign w_xlat[g]   = lk_addr;
    end
  end

  always_comb begin
    rd_val = '0;
    if (win_space) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (32'(reg_addr[7:0]) == grp_off(i))     rd_val = w_ctrl_rd[i];
        if (32'(reg_addr[7:0]) == grp_off(i) + 4) rd_val = {w_base[i], 16'h0};
        if (i < NUM_REMAP) begin
          if (32'(reg_addr[7:0]) == grp_off(i) + 8)  rd_val = w_rlo_rd[i];
          if (32'(reg_addr[7:0]) == grp_off(i) + 12) rd_val = w_rhi_rd[i];
        end
      end
    end else begin
      for (int c = 0; c < NUM_CS; c++) begin
        if (32'(reg_addr[7:0]) == c * 8)     rd_val = cs_base[c*32 +: 32];
        if (32'(reg_addr[7:0]) == c * 8 + 4) rd_val = cs_size[c*32 +: 32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
    else             reg_rdata <= '0;
  end

  always_comb begin
    lk_hit    = 1'b0;
    lk_target = '0;
    lk_attr   = '0;
    lk_xaddr  = lk_addr;
    lk_win    = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (w_match[i]) begin
        lk_hit    = 1'b1;
        lk_target = w_tgt[i];
        lk_attr   = w_attr[i];
        lk_xaddr  = w_xlat[i];
        lk_win    = WIN_W'(i);
      end
    end
  end

  for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
    wire [31:0] b = cs_base[c*32 +: 32];
    wire [31:0] s = cs_size[c*32 +: 32];
    assign c_match[c] = s[0] && (b[3:0] == 4'h0) &&
                        ((lk_addr[31:24] & ~s[31:24]) == (b[31:24] & ~s[31:24]));
  end

  always_comb begin
    dram_hit = 1'b0;
    dram_cs  = '0;
    for (int c = NUM_CS - 1; c >= 0; c--) begin
      if (c_match[c]) begin
        dram_hit = 1'b1;
        dram_cs  = CS_W'(c);
      end
    end
  end

  p_idle_rdata_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_rd) |-> reg_rdata == 32'h0);
  p_hit_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> w_en[lk_win]);
  p_offset_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_xaddr[15:0] == lk_addr[15:0]);
  p_plain_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_hit || 32'(lk_win) >= NUM_REMAP) |-> lk_xaddr == lk_addr);
  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_target == 4'h0 && lk_attr == 8'h0 && lk_win == '0));
  p_cs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dram_hit |-> (cs_size[32*dram_cs] && cs_base[32*dram_cs +: 4] == 4'h0));
  p_ctrl_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_rd) && $past(reg_addr) == 9'h000) |-> reg_rdata[3:1] == 3'b000);

endmodule

// File: tb/addr_window_decoder_bench.sv
module addr_window_decoder_bench;
  localparam int NW = 20, NR = 8, NC = 4;

  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0;
  logic [8:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, lk_addr = '0, lk_xaddr;
  logic lk_hit, dram_hit;
  logic [3:0] lk_target;
  logic [7:0] lk_attr;
  logic [4:0] lk_win;
  logic [1:0] dram_cs;
  logic [NC*32-1:0] cs_base = '0, cs_size = '0;

  always #4 clk = ~clk;

  addr_window_decoder u_addr_window_decoder (.*);

  int checks = 0, fails = 0;
  logic [31:0] m_ctrl [NW];
  logic [31:0] m_base [NW];
  logic [31:0] m_rlo  [NR];
  logic [31:0] m_rhi  [NR];

  function automatic int off(int i);
    return (i < NR) ? i * 16 : 'h90 + (i - NR) * 8;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (!a[8]) for (int i = 0; i < NW; i++) begin
      if (32'(a[7:0]) == off(i))     m_ctrl[i] = d & 32'hFFFF_FFF1;
      if (32'(a[7:0]) == off(i) + 4) m_base[i] = d & 32'hFFFF_0000;
      if (i < NR && 32'(a[7:0]) == off(i) + 8)  m_rlo[i] = d & 32'hFFFF_0000;
      if (i < NR && 32'(a[7:0]) == off(i) + 12) m_rhi[i] = d;
    end
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 0;
  endtask

  function automatic logic [31:0] exp_rd(logic [8:0] a);
    logic [31:0] v = 0;
    if (!a[8]) begin
      for (int i = 0; i < NW; i++) begin
        if (32'(a[7:0]) == off(i))     v = m_ctrl[i];
        if (32'(a[7:0]) == off(i) + 4) v = m_base[i];
        if (i < NR && 32'(a[7:0]) == off(i) + 8)  v = m_rlo[i];
        if (i < NR && 32'(a[7:0]) == off(i) + 12) v = m_rhi[i];
      end
    end else
      for (int c = 0; c < NC; c++) begin
        if (32'(a[7:0]) == c * 8)     v = cs_base[c*32 +: 32];
        if (32'(a[7:0]) == c * 8 + 4) v = cs_size[c*32 +: 32];
      end
    return v;
  endfunction

  // expected {hit, target, attr, win, xaddr}
  function automatic logic [63:0] exp_lk(logic [31:0] a);
    for (int i = 0; i < NW; i++) begin
      logic [15:0] m = m_ctrl[i][31:16];
      if (m_ctrl[i][0] && ((a[31:16] & ~m) == (m_base[i][31:16] & ~m))) begin
        logic [31:0] x = a;
        if (i < NR) x[31:16] = (m_rlo[i][31:16] & ~m) | (a[31:16] & m);
        return {1'b1, m_ctrl[i][7:4], m_ctrl[i][15:8], 5'(i), x};
      end
    end
    return {1'b0, 4'h0, 8'h0, 5'h0, a};
  endfunction

  function automatic logic [2:0] exp_cs(logic [31:0] a);
    for (int c = 0; c < NC; c++) begin
      logic [31:0] b = cs_base[c*32 +: 32], s = cs_size[c*32 +: 32];
      if (s[0] && b[3:0] == 0 && ((a[31:24] & ~s[31:24]) == (b[31:24] & ~s[31:24])))
        return {1'b1, 2'(c)};
    end
    return 3'b000;
  endfunction

  task automatic look(string req, logic [31:0] a);
    @(negedge clk);
    lk_addr = a;
    #1;
    chk(req, {lk_hit, lk_target, lk_attr, lk_win, lk_xaddr}, exp_lk(a));
    chk("R10", {61'h0, dram_hit, dram_cs}, {61'h0, exp_cs(a)});
  endtask

  bit done = 0;
  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NW; i++) begin m_ctrl[i] = 0; m_base[i] = 0; end
    for (int i = 0; i < NR; i++) begin m_rlo[i] = 0; m_rhi[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int a = 0; a < 256; a += 4) begin
      rd(9'(a), d); chk("R1", d, 0);
    end
    look("R1", 32'h0000_0000);
    look("R1", 32'hFFFF_1234);

    // R2/R3: map and field masking
    wr(9'h000, 32'hFFFF_FFFF); rd(9'h000, d); chk("R3", d, 32'hFFFF_FFF1);
    wr(9'h004, 32'h1234_5678); rd(9'h004, d); chk("R3", d, 32'h1234_0000);
    wr(9'h078, 32'hABCD_EF01); rd(9'h078, d); chk("R2", d, 32'hABCD_0000);
    wr(9'h07C, 32'hCAFE_F00D); rd(9'h07C, d); chk("R2", d, 32'hCAFE_F00D);
    wr(9'h090, 32'h0003_5A71); rd(9'h090, d); chk("R2", d, 32'h0003_5A71);
    wr(9'h0EC, 32'h7777_7777); rd(9'h0EC, d); chk("R2", d, 32'h7777_0000);
    rd(9'h098, d); chk("R2", d, 0);
    // R11: holes
    wr(9'h080, 32'hFFFF_FFFF); rd(9'h080, d); chk("R11", d, 0);
    wr(9'h0F4, 32'hFFFF_FFFF); rd(9'h0F4, d); chk("R11", d, 0);
    for (int a = 0; a < 256; a += 4) begin
      rd(9'(a), d); chk("R11", d, exp_rd(9'(a)));
    end

    // clear all
    for (int i = 0; i < NW; i++) begin wr(9'(off(i)), 0); wr(9'(off(i) + 4), 0); end
    look("R8", 32'h0000_0000);

    // R6: window 0 remap, 1 MB at 0x4000_0000 -> 0x8000_0000
    wr(9'h004, 32'h4000_0000); wr(9'h008, 32'h8000_0000);
    wr(9'h000, 32'h000F_A531);
    look("R6", 32'h4005_1234);
    look("R4", 32'h4010_0000);
    // R7: window 8 no remap
    wr(9'h094, 32'h4000_0000); wr(9'h090, 32'h001F_1271);
    look("R5", 32'h400A_0000);
    look("R7", 32'h4015_4321);
    // R8: disable window 0 keeps base
    wr(9'h000, 32'h000F_A530);
    look("R8", 32'h4005_1234);
    wr(9'h090, 0); wr(9'h094, 0);
    look("R8", 32'h4015_4321);

    // R9/R10: chip-selects
    @(negedge clk);
    cs_base = {32'h0000_0001, 32'hC000_0000, 32'h8000_0000, 32'h0000_0000};
    cs_size = {32'h3FFF_FFFF, 32'h3F00_0001, 32'h7F00_0001, 32'h0FFF_FFF0};
    wr(9'h100, 32'hFFFF_FFFF);
    for (int a = 0; a < 32; a += 4) begin
      rd(9'h100 + 9'(a), d); chk("R9", d, exp_rd(9'h100 + 9'(a)));
    end
    look("R10", 32'h0000_1000);
    look("R10", 32'h9000_0000);
    look("R10", 32'hC100_0000);
    look("R10", 32'h3000_0000);

    // random phase
    for (int it = 0; it < 150; it++) begin
      int w = $urandom % NW;
      int k = $urandom % 9;
      logic [15:0] m = 16'((32'h1 << k) - 1);
      logic [31:0] c = {m, 8'($urandom), 4'($urandom), 3'($urandom), 1'(($urandom % 4) != 0)};
      wr(9'(off(w) + 4), $urandom);
      if (w < NR) wr(9'(off(w) + 8), $urandom);
      wr(9'(off(w)), c);
      if (it % 10 == 0) begin
        cs_base[($urandom % NC)*32 +: 32] = $urandom & 32'hFF00_000F;
        cs_size[($urandom % NC)*32 +: 32] = {8'((32'h1 << ($urandom % 8)) - 1), 23'h0, 1'($urandom)};
      end
      for (int j = 0; j < 8; j++) begin
        int t = $urandom % NW;
        logic [31:0] a = $urandom;
        if (j < 6) a[31:16] = m_base[t][31:16] | (16'($urandom) & m_ctrl[t][31:16]);
        look("R5", a);
      end
      if (it % 15 == 0) begin
        int o = $urandom % 64;
        rd(9'(o * 4), d); chk("R2", d, exp_rd(9'(o * 4)));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule